// File: doc/BRIEF.md
# Prioritized Interrupt Level Encoder

This block gathers thirteen level-sensitive interrupt request lines from board peripherals and presents the most urgent enabled one to a CPU as a 4-bit interrupt-level code. Each request line owns a fixed priority level and a fixed bit in a 16-bit pending-status word. Software enables lines through a 16-bit mask register. The encoder picks the numerically smallest level among lines that are both pending and enabled, and drives that level inverted (XOR 15). When nothing qualifies, the code is 0.

The same small register window, addressed with a 6-bit byte offset over a simple synchronous bus, also holds a fixed version value, a general 16-bit output-port register that drives pins directly, and a power-off control. A write with bit 0 set to the power-off control produces a one-cycle shutdown-request pulse.

Top module: `irq_level_encoder`

## Requirements
- R1: While reset is held and after it is released, `irl_o`, `shutdown_o` and `port_o` are 0, and the mask reads back as 0.
- R2: Request input `src_i[k]` has priority level k. Its status bit is, for k = 0..12 in turn: 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15. Status bits 1, 2 and 3 belong to no input.
- R3: Status bits follow their inputs and are not latched. Once a request input drops, it no longer affects `irl_o`.
- R4: The selected level is the smallest k for which `src_i[k]` is high and the mask bit at its status position is 1. `irl_o` equals that level XOR 15. It is 0 when no input qualifies.
- R5: The mask register is at byte offset 0x00 and reads back what was written. Clearing an input's mask bit removes that input from selection.
- R6: `irl_o` is registered. It reflects the inputs present before the previous rising edge. A mask write takes effect on `irl_o` one edge after the edge that stores it.
- R7: Offset 0x30 reads as 0. A write there with data bit 0 set raises `shutdown_o` for exactly the one cycle after the write edge. A write with bit 0 clear raises nothing.
- R8: Offset 0x32 always reads 0x0010, and writes to it change nothing.
- R9: Offset 0x36 is a readable and writable 16-bit register whose value drives `port_o`.
- R10: Reads of any other offset, and any read without `bus_sel`, return 0. Writes to other offsets change neither the mask, the port nor `irl_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 13 | Request lines, index equals priority level |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| irl_o | output | 4 | Encoded interrupt level, 0 = idle |
| port_o | output | 16 | Output-port register value |
| shutdown_o | output | 1 | One-cycle shutdown request |

## Verification
The hardest situation to reach from the ports is one where a high-priority input is pending but masked while a lower-priority input is enabled. Selection must then skip the pending input, and this has to be shown for each scattered status position, including the holes at bits 1 to 3. Random source vectors combined with masks rewritten every few iterations reach these mixtures. Directed passes then clear one mask bit per level with every input high, and check that selection falls to the next level.

// File: rtl/irl_enc_pkg.sv
package irl_enc_pkg;
  localparam int NLVL = 13;
  localparam int DW   = 16;
  localparam int AW   = 6;
  localparam int LW   = 4;

  localparam logic [AW-1:0] A_MASK = 6'h00;
  localparam logic [AW-1:0] A_PWR  = 6'h30;
  localparam logic [AW-1:0] A_VER  = 6'h32;
  localparam logic [AW-1:0] A_PORT = 6'h36;
  localparam logic [DW-1:0] VER_VALUE = 16'h0010;

  // status bit position owned by each priority level
  function automatic int unsigned lvl_bit(input int unsigned lvl);
    case (lvl)
      0:  return 11;
      1:  return 9;
      2:  return 8;
      3:  return 12;
      4:  return 10;
      5:  return 6;
      6:  return 5;
      7:  return 4;
      8:  return 7;
      9:  return 14;
      10: return 13;
      11: return 0;
      default: return 15;
    endcase
  endfunction
endpackage

// File: rtl/irl_src_map.sv
module irl_src_map
  import irl_enc_pkg::*;
(
  input  logic [NLVL-1:0] src,
  output logic [DW-1:0]   stat
);
  always_comb begin
    stat = '0;
    for (int k = 0; k < NLVL; k++) begin
      stat[lvl_bit(k)] = src[k];
    end
  end
endmodule

// File: rtl/irl_prio_pick.sv
module irl_prio_pick
  import irl_enc_pkg::*;
(
  input  logic [DW-1:0] stat,
  input  logic [DW-1:0] mask,
  output logic [LW-1:0] lvl
);
  logic [NLVL-1:0] qual;

  for (genvar g = 0; g < NLVL; g++) begin : g_qual
    localparam int unsigned BP = lvl_bit(g);
    assign qual[g] = stat[BP] & mask[BP];
  end

  always_comb begin
    lvl = LW'(15);
    for (int k = NLVL - 1; k >= 0; k--) begin
      if (qual[k]) lvl = LW'(k);
    end
  end
endmodule

// File: rtl/irl_csr.sv
module irl_csr
  import irl_enc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] port_q,
  output logic          shut_q
);
  logic wr_acc, mask_en, port_en, shut_d;

  always_comb begin
    wr_acc  = sel & wr;
    mask_en = wr_acc & (addr == A_MASK);
    port_en = wr_acc & (addr == A_PORT);
    shut_d  = wr_acc & (addr == A_PWR) & wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      port_q <= '0;
      shut_q <= 1'b0;
    end else begin
      if (mask_en) mask_q <= wdata;
      if (port_en) port_q <= wdata;
      shut_q <= shut_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel && !wr) begin
      case (addr)
        A_MASK:  rdata = mask_q;
        A_PORT:  rdata = port_q;
        A_VER:   rdata = VER_VALUE;
        default: rdata = '0;
      endcase
    end
  end

  // R7
  pwr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shut_q |-> $past(sel && wr && addr == A_PWR && wdata[0]));
  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr != A_MASK) |=> $stable(mask_q));
  // R9
  port_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == A_PORT) |=> port_q == $past(wdata));
endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder
  import irl_enc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] src_i,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [LW-1:0]   irl_o,
  output logic [DW-1:0]   port_o,
  output logic            shutdown_o
);
  logic [1:0]    rst_pipe;
  logic          rst_s_n;
  logic [DW-1:0] stat, mask;
  logic [LW-1:0] lvl, irl_d, irl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  irl_src_map u_map (.src(src_i), .stat(stat));
  irl_prio_pick u_pick (.stat(stat), .mask(mask), .lvl(lvl));
  irl_csr u_csr (
    .clk(clk), .rst_n(rst_s_n), .sel(bus_sel), .wr(bus_wr),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .mask_q(mask), .port_q(port_o), .shut_q(shutdown_o)
  );

  always_comb irl_d = lvl ^ LW'(15);

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) irl_q <= '0;
    else          irl_q <= irl_d;
  end
  assign irl_o = irl_q;

  // R6
  idle_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $past(src_i == '0) |-> irl_o == '0);
  // R4
  lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (irl_o != '0) |-> ((irl_o ^ LW'(15)) < LW'(NLVL)));
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_s_n |-> (irl_o == '0 && !shutdown_o));
endmodule

// File: tb/sim_irq_level_encoder.sv
module sim_irq_level_encoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] src;
  logic        sel, wr;
  logic [5:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [3:0]  irl;
  logic [15:0] port;
  logic        shut;
  int checks = 0;
  int fails  = 0;
  logic [15:0] mask_m;

  always #2 clk = ~clk;

  irq_level_encoder u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .irl_o(irl), .port_o(port), .shutdown_o(shut)
  );

  function automatic int bitpos(input int k);
    int t[13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
    return t[k];
  endfunction

  function automatic logic [3:0] exp_irl(input logic [12:0] s, input logic [15:0] m);
    for (int k = 0; k < 13; k++)
      if (s[k] && m[bitpos(k)]) return 4'(k) ^ 4'hF;
    return 4'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [15:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic set_mask(input logic [15:0] m);
    bus_write(6'h00, m);
    mask_m = m;
    @(negedge clk);
  endtask

  task automatic apply_src(input logic [12:0] s, input string req);
    src = s;
    @(negedge clk);
    check(req, {28'b0, irl}, {28'b0, exp_irl(s, mask_m)});
  endtask

  initial begin
    #40000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    void'($urandom(32'd2718));
    rst_n = 1'b0; src = '0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0; mask_m = '0;
    repeat (3) @(negedge clk);
    check("R1 irl in reset", {28'b0, irl}, 32'h0);
    check("R1 shutdown in reset", {31'b0, shut}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 port after reset", {16'b0, port}, 32'h0);
    bus_read(6'h00, rd);
    check("R1 mask after reset", {16'b0, rd}, 32'h0);
    apply_src(13'h1FFF, "R1 all masked gives idle");

    // R5 readback, R2 each level alone
    set_mask(16'hFFFF);
    bus_read(6'h00, rd);
    check("R5 mask readback", {16'b0, rd}, 32'hFFFF);
    for (int k = 0; k < 13; k++) apply_src(13'(1) << k, "R2 single level");
    // R4 all pending picks level 0
    apply_src(13'h1FFF, "R4 all pending");
    check("R4 all pending code", {28'b0, irl}, 32'hF);
    // R3 drop
    apply_src(13'h0020, "R3 level 5 high");
    apply_src(13'h0000, "R3 level 5 dropped");
    // R5 masking each level with everything pending
    for (int k = 0; k < 12; k++) begin
      set_mask(16'hFFFF & ~(16'(1) << bitpos(k)));
      apply_src(13'h1FFF >> k << k, "R5 masked top falls through");
    end
    // R5 holes: mask only bits 1..3
    set_mask(16'h000E);
    apply_src(13'h1FFF, "R5 unused mask bits");
    // R6 timing of mask write
    src = 13'h0004;
    set_mask(16'h0000);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = 6'h00; wdata = 16'h0100;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    check("R6 mask write not yet visible", {28'b0, irl}, 32'h0);
    @(negedge clk);
    mask_m = 16'h0100;
    check("R6 mask write visible", {28'b0, irl}, 32'hD);

    // random mix
    for (int i = 0; i < 400; i++) begin
      if (i % 8 == 0) set_mask(16'($urandom));
      apply_src(13'($urandom) & 13'($urandom), "R4 random");
    end

    // R7 power-off
    bus_read(6'h30, rd);
    check("R7 power-off reads 0", {16'b0, rd}, 32'h0);
    sel = 1'b1; wr = 1'b1; addr = 6'h30; wdata = 16'h0001;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    check("R7 pulse high", {31'b0, shut}, 32'h1);
    @(negedge clk);
    check("R7 pulse ends", {31'b0, shut}, 32'h0);
    bus_write(6'h30, 16'hFFFE);
    check("R7 bit0 clear no pulse", {31'b0, shut}, 32'h0);

    // R8 version
    bus_write(6'h32, 16'hABCD);
    bus_read(6'h32, rd);
    check("R8 version", {16'b0, rd}, 32'h0010);

    // R9 output port
    bus_write(6'h36, 16'h5AC3);
    check("R9 port pins", {16'b0, port}, 32'h5AC3);
    bus_read(6'h36, rd);
    check("R9 port readback", {16'b0, rd}, 32'h5AC3);

    // R10 other offsets
    set_mask(16'h0800);
    src = 13'h0001;
    @(negedge clk);
    bus_write(6'h02, 16'h0000);
    bus_write(6'h34, 16'h0000);
    bus_write(6'h3E, 16'h1111);
    bus_read(6'h02, rd);
    check("R10 other offset reads 0", {16'b0, rd}, 32'h0);
    bus_read(6'h00, rd);
    check("R10 mask untouched", {16'b0, rd}, 32'h0800);
    check("R10 port untouched", {16'b0, port}, 32'h5AC3);
    check("R10 irl untouched", {28'b0, irl}, 32'hF);
    sel = 1'b0; wr = 1'b0; addr = 6'h00;
    #1 check("R10 no sel reads 0", {16'b0, rdata}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule